// File: doc/BRIEF.md
# Multi-Sensor Thermal Threshold Monitor

The block receives temperature samples from up to sixteen sensors. Each sample carries a sensor index, a 12-bit signed temperature code in steps of 0.1 degree, and a strobe. The monitor stores the most recent code for each sensor. It compares each incoming code against three thresholds held for that sensor: a lower bound, an upper bound and a critical bound. Every comparison that fires latches an event bit.

The event bits fall into two groups, and each group drives its own interrupt line. The first group holds the upper and lower events; the second holds the critical events. Software uses a small synchronous register bus to program thresholds, enables and masks, read the stored readings and their flags, and clear events by writing ones.

The analog sensing, code conversion and calibration happen before this block.

Top module: `thermal_monitor`

## Requirements
- R1: After reset every event status register reads 0, both interrupt outputs are low, the ready register (0xE4, bit 0) reads 0 and every per-sensor status word reads 0. Each threshold word at 0x20+4n reads 0x7FF800 (lower field 0x800, upper field 0x7FF). Each critical word at 0x60+4n reads 0x7FF.
- R2: A sample for sensor n sets the status word at 0xA0+4n as follows: bits 11:0 hold the last code, bits 16:12 are copies of code bit 11, and bit 21 marks the sensor valid. The valid bit is set from the first sample on. The ready bit (0xE4 bit 0) reads 1 once any sensor has taken a sample.
- R3: The threshold word at 0x20+4n holds the lower threshold in bits 11:0 and the upper threshold in bits 23:12. The critical word at 0x60+4n holds the critical threshold in bits 11:0. Both words read back the value that was written.
- R4: A sample whose code is at or above the sensor's upper threshold, compared as signed numbers, does two things. It latches bit n+16 of the shared event status register at 0x08, and it sets bit 18 of the sensor's status word.
- R5: A sample whose code is at or below the sensor's lower threshold, compared as signed numbers, does two things. It latches bit n of 0x08, and it sets bit 17 of the sensor's status word.
- R6: A sample whose code is at or above the sensor's critical threshold, compared as signed numbers, does two things. It latches bit n of the critical status register at 0x14, and it sets bit 19 of the sensor's status word. Critical status bits rise only on a sample.
- R7: Writing a 1 to a bit of the clear register at 0x0C clears the matching bit of 0x08. Writing a 1 to a bit of the clear register at 0x18 clears the matching bit of 0x14. When an event fires in the same cycle as the clear write, the bit stays set.
- R8: A 1 in a mask register (0x10 for the shared group, 0x1C for the critical group) keeps that status bit from raising the interrupt line. The event still latches.
- R9: The enable register at 0x04 gates the interrupt lines. Bit 0 gates the lower events, bit 1 the upper events and bit 2 the critical events. The shared line is high while an unmasked lower or upper event is latched and its enable bit is 1. The critical line is high while an unmasked critical event is latched and bit 2 is 1.
- R10: Read data appears on bus_rdata one clock edge after bus_rd is sampled, and unmapped addresses read 0. Each interrupt output is registered, so it rises one edge after the status bit that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_sensor | input | 4 | Sensor index of the sample |
| smp_code | input | 12 | Signed temperature code, 0.1 degree per step |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_band | output | 1 | Interrupt line for upper and lower events |
| irq_crit | output | 1 | Interrupt line for critical events |

## Verification
The bench first samples a code one step below the upper threshold, then a code exactly at it. A design that used a strict compare, or that placed the upper event at the wrong bit, would fail here. It applies a small positive code against a negative lower threshold; an unsigned compare would latch a false lower event. It checks that a negative reading has its sign copied into the upper status bits. It also issues a clear write in the same cycle that an event fires; a design that gave the clear priority would lose that event. It confirms that masks and enables silence the interrupt lines while events still latch, and a design that gated the status itself would show a zero status.

// File: rtl/tm_pkg.sv
package tm_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int UPPER_OFS = 16;
  localparam int SIGN_TOP  = 16;
  localparam int FLAG_LO   = 17;
  localparam int FLAG_HI   = 18;
  localparam int FLAG_CR   = 19;
  localparam int FLAG_VLD  = 21;

  localparam int A_ENABLE  = 'h04;
  localparam int A_BSTAT   = 'h08;
  localparam int A_BCLR    = 'h0C;
  localparam int A_BMASK   = 'h10;
  localparam int A_CSTAT   = 'h14;
  localparam int A_CCLR    = 'h18;
  localparam int A_CMASK   = 'h1C;
  localparam int A_THR     = 'h20;
  localparam int A_CRIT    = 'h60;
  localparam int A_STAT    = 'hA0;
  localparam int A_READY   = 'hE4;

  typedef struct packed {
    logic cr;
    logic hi;
    logic lo;
  } hit_t;
endpackage

// File: rtl/tm_compare.sv
module tm_compare #(
  parameter int CW = 12
) (
  input  logic signed [CW-1:0] code,
  input  logic signed [CW-1:0] lo_thr,
  input  logic signed [CW-1:0] hi_thr,
  input  logic signed [CW-1:0] cr_thr,
  output tm_pkg::hit_t         hit
);
  always_comb begin
    hit.lo = (code <= lo_thr);
    hit.hi = (code >= hi_thr);
    hit.cr = (code >= cr_thr);
  end
endmodule

// File: rtl/tm_sample_store.sv
module tm_sample_store #(
  parameter int N  = 16,
  parameter int CW = 12,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [CW-1:0] wr_code,
  input  tm_pkg::hit_t  wr_hit,
  input  logic [IW-1:0] rd_idx,
  output logic [CW-1:0] rd_code,
  output tm_pkg::hit_t  rd_hit,
  output logic          rd_valid,
  output logic [N-1:0]  valid_vec,
  output logic          ready
);
  logic [CW-1:0] code_mem [N];
  tm_pkg::hit_t  hit_mem  [N];

  // storage without reset so that a RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) begin
      code_mem[wr_idx] <= wr_code;
      hit_mem[wr_idx]  <= wr_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_vec <= '0;
      ready     <= 1'b0;
    end else if (wr_en) begin
      valid_vec[wr_idx] <= 1'b1;
      ready             <= 1'b1;
    end
  end

  always_comb begin
    rd_valid = valid_vec[rd_idx];
    rd_code  = rd_valid ? code_mem[rd_idx] : '0;
    rd_hit   = rd_valid ? hit_mem[rd_idx]  : '0;
  end
endmodule

// File: rtl/tm_event_latch.sv
module tm_event_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] mask_vec,
  input  logic [W-1:0] en_vec,
  output logic [W-1:0] stat,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= (stat & ~clr_vec) | set_vec;
      irq  <= |(stat & ~mask_vec & en_vec);
    end
  end
endmodule

// File: rtl/thermal_monitor.sv
module thermal_monitor #(
  parameter int N  = 16,
  parameter int CW = 12,
  parameter int IW = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      smp_valid,
  input  logic [IW-1:0]             smp_sensor,
  input  logic [CW-1:0]             smp_code,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [tm_pkg::ADDR_W-1:0] bus_addr,
  input  logic [tm_pkg::DATA_W-1:0] bus_wdata,
  output logic [tm_pkg::DATA_W-1:0] bus_rdata,
  output logic                      irq_band,
  output logic                      irq_crit
);
  import tm_pkg::*;

  localparam int BW     = DATA_W;
  localparam int SPAN   = 4 * N;
  localparam int HI_LSB = CW;
  localparam int SEXT   = SIGN_TOP - CW + 1;

  logic [CW-1:0] thr_lo [N];
  logic [CW-1:0] thr_hi [N];
  logic [CW-1:0] thr_cr [N];
  logic [2:0]    en_q;
  logic [BW-1:0] band_mask;
  logic [N-1:0]  crit_mask;
  logic [BW-1:0] band_stat, band_set, band_clr;
  logic [N-1:0]  crit_stat, crit_set, crit_clr;
  logic [N-1:0]  valid_vec;
  logic          ready;

  // address decode
  int            a;
  logic          in_thr, in_cr, in_st;
  logic [IW-1:0] thr_idx, cr_idx, st_idx;

  always_comb begin
    a       = int'(bus_addr);
    in_thr  = (a >= A_THR)  && (a < A_THR + SPAN)  && (bus_addr[1:0] == 2'b00);
    in_cr   = (a >= A_CRIT) && (a < A_CRIT + SPAN) && (bus_addr[1:0] == 2'b00);
    in_st   = (a >= A_STAT) && (a < A_STAT + SPAN) && (bus_addr[1:0] == 2'b00);
    thr_idx = IW'((a - A_THR)  >> 2);
    cr_idx  = IW'((a - A_CRIT) >> 2);
    st_idx  = IW'((a - A_STAT) >> 2);
  end

  // sample comparison
  logic         smp_ok;
  tm_pkg::hit_t hit;

  assign smp_ok = smp_valid && (int'(smp_sensor) < N);

  tm_compare #(.CW(CW)) u_cmp (
    .code   (smp_code),
    .lo_thr (thr_lo[smp_sensor]),
    .hi_thr (thr_hi[smp_sensor]),
    .cr_thr (thr_cr[smp_sensor]),
    .hit    (hit)
  );

  logic [CW-1:0] st_code;
  tm_pkg::hit_t  st_hit;
  logic          st_valid;

  tm_sample_store #(.N(N), .CW(CW), .IW(IW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (smp_ok),
    .wr_idx    (smp_sensor),
    .wr_code   (smp_code),
    .wr_hit    (hit),
    .rd_idx    (st_idx),
    .rd_code   (st_code),
    .rd_hit    (st_hit),
    .rd_valid  (st_valid),
    .valid_vec (valid_vec),
    .ready     (ready)
  );

  // event set and clear vectors
  always_comb begin
    band_set = '0;
    crit_set = '0;
    if (smp_ok) begin
      band_set[smp_sensor]             = hit.lo;
      band_set[UPPER_OFS + smp_sensor] = hit.hi;
      crit_set[smp_sensor]             = hit.cr;
    end
    band_clr = (bus_wr && a == A_BCLR) ? bus_wdata : '0;
    crit_clr = (bus_wr && a == A_CCLR) ? bus_wdata[N-1:0] : '0;
  end

  logic [BW-1:0] band_en;
  always_comb begin
    band_en = '0;
    for (int i = 0; i < N; i++) begin
      band_en[i]             = en_q[0];
      band_en[UPPER_OFS + i] = en_q[1];
    end
  end

  tm_event_latch #(.W(BW)) u_band (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (band_set),
    .clr_vec  (band_clr),
    .mask_vec (band_mask),
    .en_vec   (band_en),
    .stat     (band_stat),
    .irq      (irq_band)
  );

  tm_event_latch #(.W(N)) u_crit (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (crit_set),
    .clr_vec  (crit_clr),
    .mask_vec (crit_mask),
    .en_vec   ({N{en_q[2]}}),
    .stat     (crit_stat),
    .irq      (irq_crit)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      band_mask <= '0;
      crit_mask <= '0;
      for (int i = 0; i < N; i++) begin
        thr_lo[i] <= {1'b1, {(CW-1){1'b0}}};
        thr_hi[i] <= {1'b0, {(CW-1){1'b1}}};
        thr_cr[i] <= {1'b0, {(CW-1){1'b1}}};
      end
    end else if (bus_wr) begin
      if (a == A_ENABLE) en_q      <= bus_wdata[2:0];
      if (a == A_BMASK)  band_mask <= bus_wdata;
      if (a == A_CMASK)  crit_mask <= bus_wdata[N-1:0];
      if (in_thr) begin
        thr_lo[thr_idx] <= bus_wdata[CW-1:0];
        thr_hi[thr_idx] <= bus_wdata[HI_LSB +: CW];
      end
      if (in_cr) thr_cr[cr_idx] <= bus_wdata[CW-1:0];
    end
  end

  // read path
  logic [BW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (a == A_ENABLE) rd_next[2:0]   = en_q;
    if (a == A_BSTAT)  rd_next        = band_stat;
    if (a == A_BMASK)  rd_next        = band_mask;
    if (a == A_CSTAT)  rd_next[N-1:0] = crit_stat;
    if (a == A_CMASK)  rd_next[N-1:0] = crit_mask;
    if (a == A_READY)  rd_next[0]     = ready;
    if (in_thr) rd_next[2*CW-1:0] = {thr_hi[thr_idx], thr_lo[thr_idx]};
    if (in_cr)  rd_next[CW-1:0]   = thr_cr[cr_idx];
    if (in_st) begin
      rd_next[CW-1:0]         = st_code;
      rd_next[SIGN_TOP:CW]    = {SEXT{st_code[CW-1]}};
      rd_next[FLAG_LO]        = st_hit.lo;
      rd_next[FLAG_HI]        = st_hit.hi;
      rd_next[FLAG_CR]        = st_hit.cr;
      rd_next[FLAG_VLD]       = st_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         smp_valid,
  input logic [2:0]   en_q,
  input logic [N-1:0] crit_stat,
  input logic [N-1:0] crit_mask,
  input logic [N-1:0] valid_vec,
  input logic         ready,
  input logic         irq_band,
  input logic         irq_crit
);
  assert_band_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (en_q[1:0] == 2'b00) |=> !irq_band);

  assert_crit_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (((crit_stat & ~crit_mask) == '0) || !en_q[2]) |=> !irq_crit);

  assert_crit_rise_on_sample_R6: assert property (@(posedge clk) disable iff (rst)
    ((crit_stat & ~$past(crit_stat)) != '0) |-> $past(smp_valid));

  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (($past(valid_vec) & ~valid_vec) == '0));

  assert_ready_has_valid_R2: assert property (@(posedge clk) disable iff (rst)
    ready |-> (valid_vec != '0));
endmodule

bind thermal_monitor tm_checker #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .en_q      (en_q),
  .crit_stat (crit_stat),
  .crit_mask (crit_mask),
  .valid_vec (valid_vec),
  .ready     (ready),
  .irq_band  (irq_band),
  .irq_crit  (irq_crit)
);

// File: tb/thermal_monitor_tb.sv
module thermal_monitor_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [3:0]  smp_sensor = '0;
  logic [11:0] smp_code = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_band, irq_crit;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  thermal_monitor u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_sensor(smp_sensor),
    .smp_code(smp_code), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_band(irq_band),
    .irq_crit(irq_crit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] ad, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ad; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] ad, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ad;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic sample(input logic [3:0] s, input logic [11:0] c);
    @(negedge clk);
    smp_valid = 1'b1; smp_sensor = s; smp_code = c;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input logic [7:0] ad, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(ad, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    expect_reg("R1 band status", 8'h08, 32'h0);
    expect_reg("R1 crit status", 8'h14, 32'h0);
    expect_reg("R1 ready", 8'hE4, 32'h0);
    expect_reg("R1 status word", 8'hA0, 32'h0);
    expect_reg("R1 threshold word", 8'h20, 32'h007FF800);
    expect_reg("R1 crit word", 8'h60, 32'h7FF);
    check("R1 irq_band", {31'b0, irq_band}, 32'h0);
    check("R1 irq_crit", {31'b0, irq_crit}, 32'h0);
  endtask

  task automatic t_store();
    sample(4'd3, 12'h0FA);
    expect_reg("R2 positive reading", 8'hAC, 32'h002000FA);
    expect_reg("R2 ready", 8'hE4, 32'h1);
    sample(4'd5, 12'hF9C);
    expect_reg("R2 sign copy", 8'hB4, 32'h0021FF9C);
    expect_reg("R10 unmapped", 8'hF0, 32'h0);
  endtask

  task automatic t_thresh();
    bus_write(8'h28, 32'h0012CFCE);
    bus_write(8'h68, 32'h000001F4);
    expect_reg("R3 threshold readback", 8'h28, 32'h0012CFCE);
    expect_reg("R3 crit readback", 8'h68, 32'h1F4);
    bus_write(8'h04, 32'h7);
  endtask

  task automatic t_upper();
    sample(4'd2, 12'h12B);
    expect_reg("R4 below upper", 8'h08, 32'h0);
    sample(4'd2, 12'h12C);
    expect_reg("R4 equal upper", 8'h08, 32'h00040000);
    expect_reg("R4 status flag", 8'hA8, 32'h0024012C);
    settle();
    check("R9 irq_band on upper", {31'b0, irq_band}, 32'h1);
  endtask

  task automatic t_lower();
    sample(4'd2, 12'h010);
    expect_reg("R5 signed lower no event", 8'h08, 32'h00040000);
    expect_reg("R5 status no flag", 8'hA8, 32'h00200010);
    sample(4'd2, 12'hFCE);
    expect_reg("R5 equal lower", 8'h08, 32'h00040004);
    expect_reg("R5 status flag", 8'hA8, 32'h0023FFCE);
  endtask

  task automatic t_clear();
    bus_write(8'h0C, 32'h00040000);
    expect_reg("R7 clear upper", 8'h08, 32'h4);
    settle();
    check("R9 irq_band lower held", {31'b0, irq_band}, 32'h1);
    bus_write(8'h0C, 32'h4);
    expect_reg("R7 clear lower", 8'h08, 32'h0);
    settle();
    check("R7 irq_band after clear", {31'b0, irq_band}, 32'h0);
  endtask

  task automatic t_mask();
    bus_write(8'h10, 32'h00040000);
    sample(4'd2, 12'h12C);
    expect_reg("R8 masked still latches", 8'h08, 32'h00040000);
    settle();
    check("R8 masked irq low", {31'b0, irq_band}, 32'h0);
    bus_write(8'h10, 32'h0);
    settle();
    check("R8 unmasked irq high", {31'b0, irq_band}, 32'h1);
    bus_write(8'h04, 32'h5);
    settle();
    check("R9 upper disabled", {31'b0, irq_band}, 32'h0);
    bus_write(8'h04, 32'h7);
    bus_write(8'h0C, 32'hFFFFFFFF);
  endtask

  task automatic t_crit();
    sample(4'd2, 12'h1F3);
    expect_reg("R6 below crit", 8'h14, 32'h0);
    sample(4'd2, 12'h1F4);
    expect_reg("R6 equal crit", 8'h14, 32'h4);
    expect_reg("R6 status flags", 8'hA8, 32'h002C01F4);
    settle();
    check("R6 irq_crit", {31'b0, irq_crit}, 32'h1);
    bus_write(8'h1C, 32'h4);
    settle();
    check("R8 crit masked", {31'b0, irq_crit}, 32'h0);
    bus_write(8'h1C, 32'h0);
    bus_write(8'h04, 32'h3);
    settle();
    check("R9 crit disabled", {31'b0, irq_crit}, 32'h0);
    bus_write(8'h04, 32'h7);
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    smp_valid = 1'b1; smp_sensor = 4'd2; smp_code = 12'h1F4;
    bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h4;
    @(negedge clk);
    smp_valid = 1'b0; bus_wr = 1'b0;
    expect_reg("R7 set wins over clear", 8'h14, 32'h4);
    bus_write(8'h18, 32'h4);
    expect_reg("R7 crit cleared", 8'h14, 32'h0);
    settle();
    check("R7 irq_crit after clear", {31'b0, irq_crit}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_store();
    t_thresh();
    t_upper();
    t_lower();
    t_clear();
    t_mask();
    t_crit();
    t_set_wins();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule